// File: doc/BRIEF.md
# Serial Bus Cycle Timer

This block keeps isochronous bus time for a serial-bus link layer. A single 32-bit word holds three chained counters. The low counter is a sub-cycle offset that steps once for every tick-enable pulse. The middle counter is the 8 kHz cycle number, which steps each time the offset completes a pass. The top counter is a seconds count, which steps each time the cycle number completes a pass. The offset stage counts modulo 3072 and the cycle stage counts modulo 8000, so a tick rate of 24.576 MHz gives exact 125 µs cycles and 1 s seconds.

Software can preset the whole word in one cycle through a write port. The current value is always visible on a read port, which comes straight from the field registers, so all three fields are taken from the same clock edge. Two registered single-cycle strobes mark the start of a new cycle and the start of a new second. Each strobe rises together with the field values it announces, so logic downstream can act on the strobe and the new time value in the same cycle.

Top module: `bus_cycle_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `rd_data` is 0 and both `new_cycle` and `new_second` are 0.
- R2: The offset field is `rd_data[11:0]`. On each clock edge where `tick` is 1 and `wr_en` is 0, the offset increases by one. After 3071 it returns to 0.
- R3: The cycle number field is `rd_data[24:12]`. It increases by one only on a tick where the offset goes from 3071 to 0. After 7999 it returns to 0.
- R4: The seconds field is `rd_data[31:25]`. It increases by one only on a tick where the cycle number goes from 7999 to 0. After 127 it returns to 0 and does not saturate.
- R5: On an edge where `tick` is 0 and `wr_en` is 0, no field changes.
- R6: When `wr_en` is 1, all three fields take their values from `wr_data` at that edge, using the same bit positions as `rd_data`. A write takes priority over a `tick` in the same cycle.
- R7: If a written offset is above 3071, 3071 is stored. If a written cycle number is above 7999, 7999 is stored. The seconds field is stored as written.
- R8: `new_cycle` is 1 for exactly the one cycle after an edge where the offset wrapped from 3071 to 0. In that cycle `rd_data` already shows offset 0. A write never produces this pulse.
- R9: `new_second` is 1 for exactly the one cycle after an edge where the cycle number wrapped from 7999 to 0. It always coincides with `new_cycle`. A write never produces this pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Offset-rate enable, one offset step per high cycle |
| wr_en | input | 1 | Load all fields from `wr_data` |
| wr_data | input | 32 | Value to load as {seconds, cycle number, offset} |
| rd_data | output | 32 | Current {seconds, cycle number, offset} |
| new_cycle | output | 1 | One-cycle strobe when the offset wraps |
| new_second | output | 1 | One-cycle strobe when the cycle number wraps |

## Verification
The properties assume that `tick`, `wr_en` and `wr_data` change only between clock edges and never carry unknown values. They also assume that `tick` and `wr_en` may be high together, in which case the write wins. The stimulus drives every input on the falling edge. It includes writes with fields above their valid range, and writes placed on the same cycle as a tick. Cascades from a wrap are reached by presetting the fields just below their limits. The bench does not wait for millions of ticks.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  // default radices of the three chained fields
  localparam int OFS_MOD_D = 3072;
  localparam int CYC_MOD_D = 8000;
  localparam int SEC_W_D   = 7;
endpackage

// File: rtl/radix_digit.sv
// One bounded counter stage: counts 0..MOD-1, loads with clamping,
// and emits a registered strobe on its own wrap.
module radix_digit #(
  parameter int MOD = 3072,
  parameter int W   = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry,
  output logic         wrap_q
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] ld_fix;

  generate
    if (MOD == (1 << W)) begin : g_full
      assign ld_fix = ld_val;
    end else begin : g_clamp
      assign ld_fix = (ld_val > TOP) ? TOP : ld_val;
    end
  endgenerate

  assign carry = inc && (val == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      val    <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= carry && !ld;
      if (ld)
        val <= ld_fix;
      else if (inc)
        val <= carry ? '0 : val + 1'b1;
    end
  end
endmodule

// File: rtl/roll_digit.sv
// Top stage: power-of-two field that rolls over freely, no carry out.
module roll_digit #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)
      val <= '0;
    else if (ld)
      val <= ld_val;
    else if (inc)
      val <= val + 1'b1;
  end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int OFS_MOD = cyc_timer_pkg::OFS_MOD_D,
  parameter int CYC_MOD = cyc_timer_pkg::CYC_MOD_D,
  parameter int SEC_W   = cyc_timer_pkg::SEC_W_D,
  localparam int OFS_W  = $clog2(OFS_MOD),
  localparam int CYC_W  = $clog2(CYC_MOD),
  localparam int TOT_W  = OFS_W + CYC_W + SEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [TOT_W-1:0] wr_data,
  output logic [TOT_W-1:0] rd_data,
  output logic             new_cycle,
  output logic             new_second
);
  logic [OFS_W-1:0] ofs_val;
  logic [CYC_W-1:0] cyc_val;
  logic [SEC_W-1:0] sec_val;
  logic             ofs_carry;
  logic             cyc_carry;

  radix_digit #(.MOD(OFS_MOD), .W(OFS_W)) u_ofs (
    .clk    (clk),
    .rst    (rst),
    .inc    (tick),
    .ld     (wr_en),
    .ld_val (wr_data[OFS_W-1:0]),
    .val    (ofs_val),
    .carry  (ofs_carry),
    .wrap_q (new_cycle)
  );

  radix_digit #(.MOD(CYC_MOD), .W(CYC_W)) u_cyc (
    .clk    (clk),
    .rst    (rst),
    .inc    (ofs_carry),
    .ld     (wr_en),
    .ld_val (wr_data[OFS_W +: CYC_W]),
    .val    (cyc_val),
    .carry  (cyc_carry),
    .wrap_q (new_second)
  );

  roll_digit #(.W(SEC_W)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .inc    (cyc_carry),
    .ld     (wr_en),
    .ld_val (wr_data[TOT_W-1 -: SEC_W]),
    .val    (sec_val)
  );

  // all fields come from the same edge: no cross-field skew
  assign rd_data = {sec_val, cyc_val, ofs_val};
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk #(
  parameter int OFS_MOD = 3072,
  parameter int CYC_MOD = 8000,
  parameter int SEC_W   = 7,
  localparam int OFS_W  = $clog2(OFS_MOD),
  localparam int CYC_W  = $clog2(CYC_MOD),
  localparam int TOT_W  = OFS_W + CYC_W + SEC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [TOT_W-1:0] wr_data,
  input logic [TOT_W-1:0] rd_data,
  input logic             new_cycle,
  input logic             new_second
);
  localparam logic [OFS_W-1:0] OTOP = OFS_W'(OFS_MOD - 1);
  localparam logic [CYC_W-1:0] CTOP = CYC_W'(CYC_MOD - 1);

  logic [OFS_W-1:0] ofs, w_ofs, w_ofs_exp;
  logic [CYC_W-1:0] cyc, w_cyc, w_cyc_exp;
  logic [SEC_W-1:0] sec;
  logic             ofs_wrap_now;

  assign ofs       = rd_data[OFS_W-1:0];
  assign cyc       = rd_data[OFS_W +: CYC_W];
  assign sec       = rd_data[TOT_W-1 -: SEC_W];
  assign w_ofs     = wr_data[OFS_W-1:0];
  assign w_cyc     = wr_data[OFS_W +: CYC_W];
  assign w_ofs_exp = (w_ofs > OTOP) ? OTOP : w_ofs;
  assign w_cyc_exp = (w_cyc > CTOP) ? CTOP : w_cyc;
  assign ofs_wrap_now = tick && !wr_en && (ofs == OTOP);

  // R2
  ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
    ofs <= OTOP);
  // R3
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    cyc <= CTOP);
  // R2
  ofs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && ofs != OTOP) |=>
      (ofs == $past(ofs) + 1'b1) && $stable(cyc) && $stable(sec));
  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ofs_wrap_now && cyc != CTOP) |=>
      (ofs == '0) && (cyc == $past(cyc) + 1'b1) && $stable(sec));
  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ofs_wrap_now && cyc == CTOP) |=>
      (ofs == '0) && (cyc == '0) && (sec == $past(sec) + 1'b1));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(rd_data));
  // R6 R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ofs == $past(w_ofs_exp)) && (cyc == $past(w_cyc_exp)) &&
              (sec == $past(wr_data[TOT_W-1 -: SEC_W])));
  // R8
  cyc_pulse_on_chk: assert property (@(posedge clk) disable iff (rst)
    ofs_wrap_now |=> new_cycle && (ofs == '0));
  // R8
  cyc_pulse_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ofs_wrap_now |=> !new_cycle);
  // R9
  sec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    new_second |-> new_cycle && (cyc == '0) && (ofs == '0));
endmodule

bind bus_cycle_timer bus_cycle_timer_chk #(
  .OFS_MOD(OFS_MOD), .CYC_MOD(CYC_MOD), .SEC_W(SEC_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .new_cycle(new_cycle), .new_second(new_second)
);

// File: tb/sim_bus_cycle_timer.sv
module sim_bus_cycle_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        new_cycle;
  logic        new_second;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // scoreboard: {rd_data, new_cycle, new_second}
  logic [33:0] exp_q[$];
  int          req_q[$];

  int m_ofs = 0, m_cyc = 0, m_sec = 0;

  always #2 clk = ~clk;

  bus_cycle_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .new_cycle(new_cycle), .new_second(new_second)
  );

  function automatic logic [31:0] pack(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  // driver: apply one cycle, model it, push the expected result
  task automatic step(input logic t, input logic w, input logic [31:0] d, input int req);
    logic nc = 1'b0, ns = 1'b0;
    @(negedge clk);
    tick = t; wr_en = w; wr_data = d;
    if (w) begin
      m_ofs = (int'(d[11:0]) > 3071) ? 3071 : int'(d[11:0]);
      m_cyc = (int'(d[24:12]) > 7999) ? 7999 : int'(d[24:12]);
      m_sec = int'(d[31:25]);
    end else if (t) begin
      nc = (m_ofs == 3071);
      m_ofs = nc ? 0 : m_ofs + 1;
      if (nc) begin
        ns = (m_cyc == 7999);
        m_cyc = ns ? 0 : m_cyc + 1;
        if (ns) m_sec = (m_sec + 1) % 128;
      end
    end
    @(posedge clk);
    #1;
    exp_q.push_back({pack(m_sec, m_cyc, m_ofs), nc, ns});
    req_q.push_back(req);
  endtask

  // monitor
  logic [33:0] mon_e;
  int          mon_r;
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_r = req_q.pop_front();
      tests++;
      if ({rd_data, new_cycle, new_second} !== mon_e) begin
        fails++;
        $display("FAIL R%0d: got rd=%h nc=%b ns=%b, exp rd=%h nc=%b ns=%b",
                 mon_r, rd_data, new_cycle, new_second,
                 mon_e[33:2], mon_e[1], mon_e[0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: value during reset
    repeat (2) @(negedge clk);
    tests++;
    if ({rd_data, new_cycle, new_second} !== 34'd0) begin
      fails++;
      $display("FAIL R1: got %h %b %b, exp 0 0 0", rd_data, new_cycle, new_second);
    end
    rst = 1'b0;
    step(1'b0, 1'b0, 32'd0, 1);                     // R1 first cycle out of reset
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'd0, 2);   // R2
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 32'd0, 5);   // R5
    // R3 and R8: offset wraps into cycle 6
    step(1'b0, 1'b1, pack(3, 5, 3069), 6);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'd0, 8);
    // R7: out-of-range fields are clamped
    step(1'b0, 1'b1, {7'd9, 13'h1FFF, 12'hFFF}, 7);
    step(1'b0, 1'b0, 32'd0, 7);
    // R9 and R4: cycle number wraps, seconds advance
    step(1'b1, 1'b0, 32'd0, 9);
    step(1'b1, 1'b0, 32'd0, 4);
    // R4: seconds roll 127 -> 0
    step(1'b0, 1'b1, pack(127, 7999, 3070), 6);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 32'd0, 4);
    // R6: write wins over a coincident tick, even at the wrap point
    step(1'b0, 1'b1, pack(1, 7999, 3071), 6);
    step(1'b1, 1'b1, pack(2, 40, 100), 6);
    step(1'b1, 1'b0, 32'd0, 3);
    // R5: alternating tick pattern
    for (int i = 0; i < 8; i++) step(1'(i % 2), 1'b0, 32'd0, 5);
    // R2 and R3: a full natural offset pass
    for (int i = 0; i < 3100; i++) step(1'b1, 1'b0, 32'd0, 2);
    // R8: a write at 3071 gives no pulse
    step(1'b0, 1'b1, pack(0, 0, 3071), 8);
    step(1'b0, 1'b0, 32'd0, 8);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule